// File: doc/BRIEF.md
# Reset Strap Latch and Address Pin Multiplexer

This block owns the lowest address pins of the external program-memory bus during and just after chip reset. While the active-low chip reset pin is held, those pins are inputs with weak pulls, and their levels act as configuration straps. Address pins 1:0 choose the clock frequency, pin 2 the clock source and pin 3 the polarity of the IR transmit LED. A separate pin chooses internal ROM or external program memory. When reset is released, the block spends one capture cycle sampling the straps with the pulls still on. It then turns the pulls off, hands the pins back to address duty and enables the program-memory chip select.

The reset pin is synchronized into the core clock and qualified by a minimum low time, so glitches shorter than about 1 µs are ignored. After reset the latched straps are exported as status bits. A reserved frequency code raises an error bit and falls back to 24 MHz. When the processor is idle, interrupt 2 is not pending and the clock-select sleep bit is set, the block enters a standby state. In that state the chip select is negated and every low address pin whose latched strap was 1 is floated.

The controller has four states. ST_HOLD is entered on power-on reset or on a qualified chip reset and is left when the synchronized pin reads high. ST_CAPTURE lasts one cycle and moves to ST_RUN. ST_RUN moves to ST_STANDBY when the standby condition holds. ST_STANDBY returns to ST_RUN when the condition drops. From ST_CAPTURE, ST_RUN or ST_STANDBY, a qualified reset goes to ST_HOLD.

Top module: `strap_pinmux`

## Requirements
- R1: The chip reset pin passes through a two-stage synchronizer. The block enters ST_HOLD only after the synchronized pin has read low for MIN_LOW_CYC consecutive cycles (24 by default). A shorter low pulse leaves every output unchanged.
- R2: In ST_HOLD and ST_CAPTURE, ma_pd_en is 3'b111, ma3_pu_en and memsel_pu_en are 1, ma_oe is 4'b0000 and mem_ce_n is 1.
- R3: Once the synchronized pin reads high in ST_HOLD, exactly one ST_CAPTURE cycle follows, with the pulls still on. The straps are sampled at the end of that cycle, and the block is then in ST_RUN.
- R4: Frequency code pad_ma_in[1:0]: 2'b00 gives st_freq_48m=0, 2'b11 gives st_freq_48m=1, and 2'b01 or 2'b10 give st_freq_err=1 with st_freq_48m=0 (24 MHz).
- R5: st_clk_ext equals the captured pad_ma_in[2] (0 crystal, 1 external clock). st_ir_tx_pol equals the captured pad_ma_in[3].
- R6: st_rom_internal equals the captured pad_memsel_in (1 internal ROM, 0 external memory).
- R7: In ST_RUN every pull is off, ma_oe is 4'b1111 and mem_ce_n is 0.
- R8: ST_STANDBY is entered one cycle after cpu_idle=1, int2_req=0 and clk_sleep=1 are seen together in ST_RUN, and is left one cycle after that condition drops. In ST_STANDBY, mem_ce_n is 1, ma_oe[3] is 1 and ma_oe[i] for i in 0..2 is the inverse of the captured strap bit i.
- R9: Outside the capture cycle the status bits hold their values whatever the pad inputs do.
- R10: The standby inputs have no effect in ST_HOLD: the pulls stay on and mem_ce_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| chip_rst_n | input | 1 | Asynchronous chip reset pin, active low |
| pad_ma_in | input | 4 | Pad input levels of address pins 3:0 |
| pad_memsel_in | input | 1 | Pad input level of the program-memory select strap |
| cpu_idle | input | 1 | Processor idle bit |
| int2_req | input | 1 | Interrupt 2 pending, active high |
| clk_sleep | input | 1 | Sleep bit of the clock-select register |
| ma_pd_en | output | 3 | Weak pull-down enables for address pins 2:0 |
| ma3_pu_en | output | 1 | Weak pull-up enable for address pin 3 |
| memsel_pu_en | output | 1 | Weak pull-up enable for the memory-select strap pin |
| ma_oe | output | 4 | Output enables for address pins 3:0 |
| mem_ce_n | output | 1 | Program-memory chip enable, active low |
| st_clk_ext | output | 1 | Latched clock source (1 external) |
| st_freq_48m | output | 1 | Latched frequency is 48 MHz |
| st_freq_err | output | 1 | Latched frequency code was reserved |
| st_ir_tx_pol | output | 1 | Latched IR transmit polarity |
| st_rom_internal | output | 1 | Latched program-memory choice (1 internal ROM) |

## Verification
The assertions assume three things about the inputs. The standby inputs are synchronous to clk. The strap pads are steady from before the reset pin rises until the capture cycle is over. MIN_LOW_CYC is at least 2, which lets a qualified reset imply a low reading on the previous cycle. The stimulus changes strap levels only at the moment the reset pin is released or well inside ST_RUN, and drives every input on the falling clock edge. Reset pulses of MIN_LOW_CYC-1 and exactly MIN_LOW_CYC synchronized cycles probe the qualifier boundary.

// File: rtl/strap_pinmux_pkg.sv
package strap_pinmux_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_RUN     = 2'd2,
        ST_STANDBY = 2'd3
    } strap_state_e;

    // bit order follows the pad order: [1:0] freq code, [2] clock source, [3] IR polarity
    typedef struct packed {
        logic       mem_internal;
        logic       ir_pol;
        logic       clk_ext;
        logic [1:0] fsel;
    } strap_word_t;

    function automatic logic is_48m(input logic [1:0] code);
        return code == 2'b11;
    endfunction

    function automatic logic is_reserved(input logic [1:0] code);
        return code == 2'b01 || code == 2'b10;
    endfunction

endpackage

// File: rtl/strap_rst_qual.sv
module strap_rst_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW_CYC = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    output logic released_o,
    output logic long_low_o
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin_n};
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt_q <= '0;
        end else if (synced) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != LAST) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign released_o = synced;
    assign long_low_o = !synced && (low_cnt_q == LAST);

    AST_HIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!por_n)
        long_low_o |-> $past(!synced)); // R1

endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
    import strap_pinmux_pkg::*;
(
    input  logic         clk,
    input  logic         por_n,
    input  logic         released_i,
    input  logic         long_low_i,
    input  logic         stby_req_i,
    input  strap_word_t  pad_strap_i,
    output strap_state_e state_o,
    output strap_word_t  cap_o
);
    strap_state_e state_q, state_d;
    strap_word_t  cap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:    state_d = released_i ? ST_CAPTURE : ST_HOLD;
            ST_CAPTURE: state_d = long_low_i ? ST_HOLD : ST_RUN;
            ST_RUN: begin
                if (long_low_i)      state_d = ST_HOLD;
                else if (stby_req_i) state_d = ST_STANDBY;
                else                 state_d = ST_RUN;
            end
            ST_STANDBY: begin
                if (long_low_i)       state_d = ST_HOLD;
                else if (!stby_req_i) state_d = ST_RUN;
                else                  state_d = ST_STANDBY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                     cap_q <= '0;
        else if (state_q == ST_CAPTURE) cap_q <= pad_strap_i;
    end

    assign state_o = state_q;
    assign cap_o   = cap_q;

    AST_HOLD_ON_LONG_LOW: assert property (@(posedge clk) disable iff (!por_n)
        long_low_i |=> state_q == ST_HOLD); // R1
    AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        state_q == ST_CAPTURE |=> state_q == ST_RUN); // R3
    AST_STRAPS_STABLE: assert property (@(posedge clk) disable iff (!por_n)
        ((state_q inside {ST_RUN, ST_STANDBY}) &&
         ($past(state_q) inside {ST_RUN, ST_STANDBY})) |-> $stable(cap_q)); // R9
    AST_STBY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_STANDBY) |-> $past(stby_req_i)); // R8

endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl
    import strap_pinmux_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int FLOAT_W = 3
) (
    input  strap_state_e      state_i,
    input  strap_word_t       cap_i,
    output logic [FLOAT_W-1:0] pd_en_o,
    output logic              ir_pu_en_o,
    output logic              mem_pu_en_o,
    output logic [ADDR_W-1:0] addr_oe_o,
    output logic              mem_ce_n_o,
    output logic              clk_ext_o,
    output logic              freq_48m_o,
    output logic              freq_err_o,
    output logic              ir_pol_o,
    output logic              mem_internal_o
);
    logic [FLOAT_W-1:0] cap_bits;
    logic [FLOAT_W-1:0] stby_oe;

    assign cap_bits = FLOAT_W'({cap_i.clk_ext, cap_i.fsel});

    for (genvar gi = 0; gi < FLOAT_W; gi++) begin : g_float
        assign stby_oe[gi] = ~cap_bits[gi];
    end

    always_comb begin
        pd_en_o     = '0;
        ir_pu_en_o  = 1'b0;
        mem_pu_en_o = 1'b0;
        addr_oe_o   = '1;
        mem_ce_n_o  = 1'b0;
        unique case (state_i)
            ST_HOLD, ST_CAPTURE: begin
                pd_en_o     = '1;
                ir_pu_en_o  = 1'b1;
                mem_pu_en_o = 1'b1;
                addr_oe_o   = '0;
                mem_ce_n_o  = 1'b1;
            end
            ST_RUN: begin
                mem_ce_n_o = 1'b0;
            end
            ST_STANDBY: begin
                addr_oe_o[FLOAT_W-1:0] = stby_oe;
                mem_ce_n_o = 1'b1;
            end
        endcase
    end

    assign clk_ext_o      = cap_i.clk_ext;
    assign freq_48m_o     = is_48m(cap_i.fsel);
    assign freq_err_o     = is_reserved(cap_i.fsel);
    assign ir_pol_o       = cap_i.ir_pol;
    assign mem_internal_o = cap_i.mem_internal;

    always_comb begin
        AST_PULL_OE_EXCLUSIVE: assert (!(|pd_en_o) || (addr_oe_o == '0)); // R2
        AST_ERR_FALLS_TO_24M: assert (!freq_err_o || !freq_48m_o); // R4
    end

endmodule

// File: rtl/strap_pinmux.sv
module strap_pinmux
    import strap_pinmux_pkg::*;
#(
    parameter int REF_CLK_MHZ  = 24,
    parameter int MIN_PULSE_NS = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       chip_rst_n,
    input  logic [3:0] pad_ma_in,
    input  logic       pad_memsel_in,
    input  logic       cpu_idle,
    input  logic       int2_req,
    input  logic       clk_sleep,
    output logic [2:0] ma_pd_en,
    output logic       ma3_pu_en,
    output logic       memsel_pu_en,
    output logic [3:0] ma_oe,
    output logic       mem_ce_n,
    output logic       st_clk_ext,
    output logic       st_freq_48m,
    output logic       st_freq_err,
    output logic       st_ir_tx_pol,
    output logic       st_rom_internal
);
    localparam int MIN_LOW_CYC = (REF_CLK_MHZ * MIN_PULSE_NS) / 1000;
    localparam int ADDR_W      = 4;
    localparam int FLOAT_W     = 3;

    logic         released;
    logic         long_low;
    logic         stby_req;
    strap_word_t  pad_strap;
    strap_word_t  cap;
    strap_state_e state;

    assign stby_req  = cpu_idle & ~int2_req & clk_sleep;
    assign pad_strap = '{mem_internal: pad_memsel_in, ir_pol: pad_ma_in[3],
                         clk_ext: pad_ma_in[2], fsel: pad_ma_in[1:0]};

    strap_rst_qual #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_LOW_CYC(MIN_LOW_CYC)
    ) u_qual (
        .clk        (clk),
        .por_n      (por_n),
        .rst_pin_n  (chip_rst_n),
        .released_o (released),
        .long_low_o (long_low)
    );

    strap_fsm u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .released_i  (released),
        .long_low_i  (long_low),
        .stby_req_i  (stby_req),
        .pad_strap_i (pad_strap),
        .state_o     (state),
        .cap_o       (cap)
    );

    strap_pad_ctrl #(
        .ADDR_W (ADDR_W),
        .FLOAT_W(FLOAT_W)
    ) u_pad (
        .state_i        (state),
        .cap_i          (cap),
        .pd_en_o        (ma_pd_en),
        .ir_pu_en_o     (ma3_pu_en),
        .mem_pu_en_o    (memsel_pu_en),
        .addr_oe_o      (ma_oe),
        .mem_ce_n_o     (mem_ce_n),
        .clk_ext_o      (st_clk_ext),
        .freq_48m_o     (st_freq_48m),
        .freq_err_o     (st_freq_err),
        .ir_pol_o       (st_ir_tx_pol),
        .mem_internal_o (st_rom_internal)
    );

    AST_HOLD_MEANS_CE_OFF: assert property (@(posedge clk) disable iff (!por_n)
        (memsel_pu_en && !$rose(memsel_pu_en)) |-> mem_ce_n); // R10

endmodule

// File: tb/strap_pinmux_tb.sv
module strap_pinmux_tb;
    localparam int N = 24;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic chip_rst_n = 1'b0;
    logic [3:0] pad_ma_in = 4'b0000;
    logic pad_memsel_in = 1'b0;
    logic cpu_idle = 1'b0, int2_req = 1'b0, clk_sleep = 1'b0;
    logic [2:0] ma_pd_en;
    logic ma3_pu_en, memsel_pu_en, mem_ce_n;
    logic [3:0] ma_oe;
    logic st_clk_ext, st_freq_48m, st_freq_err, st_ir_tx_pol, st_rom_internal;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;
    bit seen_hold = 1'b0;

    always #2 clk = ~clk;

    strap_pinmux u_dut (
        .clk(clk), .por_n(por_n), .chip_rst_n(chip_rst_n),
        .pad_ma_in(pad_ma_in), .pad_memsel_in(pad_memsel_in),
        .cpu_idle(cpu_idle), .int2_req(int2_req), .clk_sleep(clk_sleep),
        .ma_pd_en(ma_pd_en), .ma3_pu_en(ma3_pu_en), .memsel_pu_en(memsel_pu_en),
        .ma_oe(ma_oe), .mem_ce_n(mem_ce_n), .st_clk_ext(st_clk_ext),
        .st_freq_48m(st_freq_48m), .st_freq_err(st_freq_err),
        .st_ir_tx_pol(st_ir_tx_pol), .st_rom_internal(st_rom_internal)
    );

    // behavioural reference: 0 hold, 1 capture, 2 run, 3 standby
    int m_st = 0, m_low = 0;
    logic m_s1 = 1'b0, m_s2 = 1'b0;
    logic [3:0] m_cap = 4'b0;
    logic m_capm = 1'b0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_st = 0; m_low = 0; m_s1 = 1'b0; m_s2 = 1'b0; m_cap = 4'b0; m_capm = 1'b0;
        end else begin
            bit hit, req;
            int nxt;
            hit = !m_s2 && (m_low >= N - 1);
            req = cpu_idle && !int2_req && clk_sleep;
            nxt = m_st;
            case (m_st)
                0: if (m_s2) nxt = 1;
                1: nxt = hit ? 0 : 2;
                2: nxt = hit ? 0 : (req ? 3 : 2);
                default: nxt = hit ? 0 : (req ? 3 : 2);
            endcase
            if (m_st == 1) begin m_cap = pad_ma_in; m_capm = pad_memsel_in; end
            if (m_s2) m_low = 0; else if (m_low < N - 1) m_low = m_low + 1;
            m_s2 = m_s1; m_s1 = chip_rst_n; m_st = nxt;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (por_n && cmp_en) begin
            string rq;
            logic [3:0] e_oe;
            logic [2:0] e_pd;
            logic e_pu, e_ce;
            if (m_st <= 1) begin rq = "R2"; e_pd = 3'b111; e_pu = 1; e_oe = 4'h0; e_ce = 1; end
            else if (m_st == 2) begin rq = "R7"; e_pd = 3'b000; e_pu = 0; e_oe = 4'hF; e_ce = 0; end
            else begin rq = "R8"; e_pd = 3'b000; e_pu = 0; e_oe = {1'b1, ~m_cap[2:0]}; e_ce = 1; end
            if (mem_ce_n && memsel_pu_en) seen_hold = 1'b1;
            chk(rq, "pull_down", int'(ma_pd_en), int'(e_pd));
            chk(rq, "pull_up", int'({ma3_pu_en, memsel_pu_en}), int'({e_pu, e_pu}));
            chk(rq, "addr_oe", int'(ma_oe), int'(e_oe));
            chk(rq, "ce_n", int'(mem_ce_n), int'(e_ce));
            chk("R4", "freq48", int'(st_freq_48m), int'(m_cap[1:0] == 2'b11));
            chk("R4", "freq_err", int'(st_freq_err), int'(m_cap[1:0] == 2'b01 || m_cap[1:0] == 2'b10));
            chk("R5", "clk_ext/pol", int'({st_clk_ext, st_ir_tx_pol}), int'({m_cap[2], m_cap[3]}));
            chk("R6", "rom_internal", int'(st_rom_internal), int'(m_capm));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold reset low, release with given straps, return at first ST_RUN negedge
    task automatic do_reset(input logic [3:0] ma, input logic ms, input int low_cyc);
        chip_rst_n = 1'b0;
        cyc(low_cyc);
        pad_ma_in = ma; pad_memsel_in = ms;
        chip_rst_n = 1'b1;
        cyc(3);
        chk("R3", "capture_pulls", int'(ma_pd_en), 7);
        chk("R3", "capture_ce", int'(mem_ce_n), 1);
        cyc(1);
        chk("R3", "run_ce", int'(mem_ce_n), 0);
        chk("R3", "run_pulls", int'(ma_pd_en), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        cyc(4);
        por_n = 1'b1;
        cmp_en = 1'b1;
        cyc(5);
        chk("R2", "reset_ce", int'(mem_ce_n), 1);
        chk("R2", "reset_oe", int'(ma_oe), 0);
        // R10: standby inputs while held
        cpu_idle = 1; clk_sleep = 1; int2_req = 0;
        cyc(3);
        chk("R10", "hold_pulls", int'(ma_pd_en), 7);
        chk("R10", "hold_ce", int'(mem_ce_n), 1);
        cpu_idle = 0; clk_sleep = 0;
        do_reset(4'b1111, 1'b0, 2);
        chk("R4", "freq48_first", int'(st_freq_48m), 1);
        chk("R5", "clk_ext_first", int'(st_clk_ext), 1);
        chk("R6", "rom_ext_first", int'(st_rom_internal), 0);
        cyc(5);
        // R9: pad changes in run
        pad_ma_in = 4'b0000; pad_memsel_in = 1'b1;
        cyc(6);
        chk("R9", "status_hold", int'({st_freq_48m, st_clk_ext, st_ir_tx_pol, st_rom_internal}), 4'b1110);
        // R8: standby with all three strap bits 1 -> all float
        cpu_idle = 1; clk_sleep = 1;
        cyc(1);
        chk("R8", "stby_entry", int'(mem_ce_n), 1);
        chk("R8", "stby_oe", int'(ma_oe), 4'b1000);
        cyc(3);
        int2_req = 1;
        cyc(1);
        chk("R8", "stby_exit", int'(mem_ce_n), 0);
        int2_req = 0; cpu_idle = 0; clk_sleep = 0;
        cyc(4);
        // R1: short pulse, one cycle below threshold
        seen_hold = 1'b0;
        chip_rst_n = 1'b0;
        cyc(N - 1);
        chip_rst_n = 1'b1;
        cyc(6);
        chk("R1", "short_pulse_ignored", int'(seen_hold), 0);
        // R1: exactly threshold length enters hold
        do_reset(4'b0100, 1'b1, N);
        chk("R1", "threshold_pulse_held", int'(seen_hold), 1);
        chk("R4", "freq24", int'({st_freq_48m, st_freq_err}), 0);
        chk("R6", "rom_int", int'(st_rom_internal), 1);
        cpu_idle = 1; clk_sleep = 1;
        cyc(2);
        chk("R8", "stby_oe_mixed", int'(ma_oe), 4'b1011);
        cpu_idle = 0; clk_sleep = 0;
        cyc(2);
        do_reset(4'b1001, 1'b0, N + 10);
        chk("R4", "reserved01", int'({st_freq_err, st_freq_48m}), 2'b10);
        chk("R5", "pol", int'({st_ir_tx_pol, st_clk_ext}), 2'b10);
        cyc(3);
        do_reset(4'b0010, 1'b1, N + 3);
        chk("R4", "reserved10", int'({st_freq_err, st_freq_48m}), 2'b10);
        cyc(5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule